// File: doc/BRIEF.md
# Match-Event Timer Core

This block is a 32-bit up-counting timer whose period and all compare points come from a pool of generic numbered events rather than from dedicated period or duty registers. There are sixteen match registers, each paired with a reload register, and sixteen events. Each event has a control word that picks which match register it compares against and how it combines conditions. Each event also has a state-mask word. A limit mask chooses which events send the counter back to zero, so one event normally defines the period that every channel shares. The other events mark compare points inside that period.

The core is programmed over a simple register bus: an address, a write strobe, write data, and combinational read data. It drives a 16-bit event vector. A bit of that vector is high for exactly one clock in every cycle where its event fires. Logic further downstream turns these pulses into set and clear actions on output pins.

A prescaler divides the count-enable input, and a halt bit freezes the core. When reload is enabled, new match values are copied in from the reload registers only when the counter restarts. A new period or duty therefore takes effect cleanly at a period boundary.

Top module: `evt_timer_core`

## Requirements
- R1: After reset the counter is 0, the halt bit is set (control register at 0x004 reads 0x00000004), every event control word reads 0, and the event vector is 0.
- R2: The following read back exactly as written: the config register at 0x000 (bit 0 = 32-bit unified mode flag, bit 7 = reload inhibit), the control register at 0x004 (bit 2 = halt, bit 4 = count-direction flag, stored only, bits 12:5 = prescaler), the limit mask at 0x008, the match registers at 0x100+4n, the reload registers at 0x200+4n, the state masks at 0x300+8n and the event control words at 0x304+8n.
- R3: Event n fires during a counter step when all of the following hold: the counter equals the match register chosen by bits 3:0 of its control word, the combine field in bits 13:12 equals 1 (match only), and bit 0 of its state mask is set.
- R4: When an event whose bit is set in the limit mask fires, the next step loads the counter with 0. A period match value of N-1 therefore repeats that event every N counts, and a compare event with match value D fires D+1 counts after each period event, provided D is not greater than N-1.
- R5: The counter takes one step every (prescaler+1) clock cycles in which the count-enable input is high.
- R6: While the halt bit is set, the counter holds its value and the event vector stays 0.
- R7: An event whose state-mask bit 0 is clear never fires.
- R8: An event never fires if its control word is 0 or if its combine field holds any value other than 1.
- R9: While the reload inhibit bit is clear, a limit-triggered restart copies every reload register into its match register. A write to a reload register alone leaves the match register unchanged until that restart.
- R10: While the reload inhibit bit is set, restarts leave the match registers unchanged.
- R11: While the count-enable input is low, the counter and prescaler hold and no event fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en | input | 1 | Count enable, divided by the prescaler |
| bus_addr | input | 12 | Register byte address |
| bus_we | input | 1 | Write strobe, register written at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| evt_o | output | 16 | One-cycle pulse per event that fires |

## Verification
The hardest case to reach from the ports is the deferred reload. It requires a match register that still holds its old value while its reload register already holds a new one, seen just before a period boundary. The stimulus gets there by halting the counter, writing only the reload register, reading the match register back, and then releasing the halt. The bench then watches for the period interval to switch to the new value only after a restart, and repeats the same sequence with reload inhibited. Period and compare timing across several prescaler settings is checked by measuring the spacing between event pulses, not by reading any internal count.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
    localparam int unsigned CNT_W   = 32;
    localparam int unsigned N_EVT   = 16;
    localparam int unsigned N_MATCH = 16;
    localparam int unsigned DIV_W   = 8;
    localparam int unsigned ADDR_W  = 12;

    // Fixed register addresses
    localparam logic [ADDR_W-1:0] A_CFG   = 12'h000;
    localparam logic [ADDR_W-1:0] A_CTL   = 12'h004;
    localparam logic [ADDR_W-1:0] A_LIMIT = 12'h008;

    // Region codes held in address bits 11:8
    localparam logic [3:0] RG_MATCH  = 4'h1;
    localparam logic [3:0] RG_RELOAD = 4'h2;
    localparam logic [3:0] RG_EVENT  = 4'h3;

    // Bit positions
    localparam int unsigned CFG_JOIN    = 0;
    localparam int unsigned CFG_KEEP    = 7;
    localparam int unsigned CTL_FREEZE  = 2;
    localparam int unsigned CTL_UPDOWN  = 4;
    localparam int unsigned CTL_DIV_LSB = 5;
    localparam int unsigned EVC_MODE_LSB = 12;
    localparam int unsigned MODE_W      = 2;
    localparam logic [MODE_W-1:0] MODE_MATCH_ONLY = 2'd1;
endpackage

// File: rtl/evt_regfile.sv
module evt_regfile
    import evt_timer_pkg::*;
#(
    parameter int unsigned P_CNT_W   = CNT_W,
    parameter int unsigned P_N_EVT   = N_EVT,
    parameter int unsigned P_N_MATCH = N_MATCH,
    parameter int unsigned P_DIV_W   = DIV_W,
    localparam int unsigned SEL_W    = $clog2(P_N_MATCH),
    localparam int unsigned EIX_W    = $clog2(P_N_EVT)
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [ADDR_W-1:0]                    bus_addr_i,
    input  logic                                 bus_we_i,
    input  logic [P_CNT_W-1:0]                   bus_wdata_i,
    output logic [P_CNT_W-1:0]                   bus_rdata_o,
    input  logic                                 restart_i,
    output logic                                 freeze_o,
    output logic [P_DIV_W-1:0]                   div_o,
    output logic [P_N_EVT-1:0]                   limit_o,
    output logic [P_N_MATCH-1:0][P_CNT_W-1:0]    match_o,
    output logic [P_N_EVT-1:0][SEL_W-1:0]        sel_o,
    output logic [P_N_EVT-1:0][MODE_W-1:0]       mode_o,
    output logic [P_N_EVT-1:0]                   arm_o
);
    typedef struct packed {
        logic                              join32;
        logic                              keep;
        logic                              freeze;
        logic                              updown;
        logic [P_DIV_W-1:0]                div;
        logic [P_N_EVT-1:0]                limit;
        logic [P_N_MATCH-1:0][P_CNT_W-1:0] match;
        logic [P_N_MATCH-1:0][P_CNT_W-1:0] reload;
        logic [P_N_EVT-1:0][P_CNT_W-1:0]   evmask;
        logic [P_N_EVT-1:0][P_CNT_W-1:0]   evctl;
    } regs_t;

    regs_t r_d, r_q;

    logic [3:0]       region;
    logic [5:0]       woff;
    logic [4:0]       eoff;
    logic             m_ok, e_ok;
    logic [SEL_W-1:0] m_idx;
    logic [EIX_W-1:0] e_idx;

    always_comb begin
        region = bus_addr_i[11:8];
        woff   = bus_addr_i[7:2];
        eoff   = bus_addr_i[7:3];
        m_ok   = ({26'd0, woff} < 32'(P_N_MATCH)) && (bus_addr_i[1:0] == 2'b00);
        e_ok   = ({27'd0, eoff} < 32'(P_N_EVT)) && (bus_addr_i[1:0] == 2'b00);
        m_idx  = woff[SEL_W-1:0];
        e_idx  = eoff[EIX_W-1:0];
    end

    // Next-state: reload at restart, then bus write has priority
    always_comb begin
        r_d = r_q;
        if (restart_i && !r_q.keep) begin
            r_d.match = r_q.reload;
        end
        if (bus_we_i) begin
            if (bus_addr_i == A_CFG) begin
                r_d.join32 = bus_wdata_i[CFG_JOIN];
                r_d.keep   = bus_wdata_i[CFG_KEEP];
            end else if (bus_addr_i == A_CTL) begin
                r_d.freeze = bus_wdata_i[CTL_FREEZE];
                r_d.updown = bus_wdata_i[CTL_UPDOWN];
                r_d.div    = bus_wdata_i[CTL_DIV_LSB +: P_DIV_W];
            end else if (bus_addr_i == A_LIMIT) begin
                r_d.limit = bus_wdata_i[P_N_EVT-1:0];
            end else if (region == RG_MATCH && m_ok) begin
                r_d.match[m_idx] = bus_wdata_i;
            end else if (region == RG_RELOAD && m_ok) begin
                r_d.reload[m_idx] = bus_wdata_i;
            end else if (region == RG_EVENT && e_ok) begin
                if (bus_addr_i[2]) r_d.evctl[e_idx]  = bus_wdata_i;
                else               r_d.evmask[e_idx] = bus_wdata_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.freeze <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    // Read mux
    always_comb begin
        bus_rdata_o = '0;
        if (bus_addr_i == A_CFG) begin
            bus_rdata_o[CFG_JOIN] = r_q.join32;
            bus_rdata_o[CFG_KEEP] = r_q.keep;
        end else if (bus_addr_i == A_CTL) begin
            bus_rdata_o[CTL_FREEZE] = r_q.freeze;
            bus_rdata_o[CTL_UPDOWN] = r_q.updown;
            bus_rdata_o[CTL_DIV_LSB +: P_DIV_W] = r_q.div;
        end else if (bus_addr_i == A_LIMIT) begin
            bus_rdata_o[P_N_EVT-1:0] = r_q.limit;
        end else if (region == RG_MATCH && m_ok) begin
            bus_rdata_o = r_q.match[m_idx];
        end else if (region == RG_RELOAD && m_ok) begin
            bus_rdata_o = r_q.reload[m_idx];
        end else if (region == RG_EVENT && e_ok) begin
            bus_rdata_o = bus_addr_i[2] ? r_q.evctl[e_idx] : r_q.evmask[e_idx];
        end
    end

    assign freeze_o = r_q.freeze;
    assign div_o    = r_q.div;
    assign limit_o  = r_q.limit;
    assign match_o  = r_q.match;

    for (genvar n = 0; n < P_N_EVT; n++) begin : g_fields
        assign sel_o[n]  = r_q.evctl[n][SEL_W-1:0];
        assign mode_o[n] = r_q.evctl[n][EVC_MODE_LSB +: MODE_W];
        assign arm_o[n]  = r_q.evmask[n][0];
    end
endmodule

// File: rtl/evt_counter.sv
module evt_counter
    import evt_timer_pkg::*;
#(
    parameter int unsigned P_CNT_W = CNT_W,
    parameter int unsigned P_DIV_W = DIV_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cnt_en_i,
    input  logic               freeze_i,
    input  logic [P_DIV_W-1:0] div_i,
    input  logic               restart_i,
    output logic [P_CNT_W-1:0] count_o,
    output logic               step_o
);
    typedef struct packed {
        logic [P_DIV_W-1:0] pre;
        logic [P_CNT_W-1:0] cnt;
    } cstate_t;

    cstate_t s_d, s_q;
    logic    run;

    assign run    = cnt_en_i && !freeze_i;
    assign step_o = run && (s_q.pre >= div_i);

    always_comb begin
        s_d = s_q;
        if (run) begin
            if (s_q.pre >= div_i) begin
                s_d.pre = '0;
                s_d.cnt = restart_i ? '0 : s_q.cnt + 1'b1;
            end else begin
                s_d.pre = s_q.pre + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign count_o = s_q.cnt;
endmodule

// File: rtl/evt_match.sv
module evt_match
    import evt_timer_pkg::*;
#(
    parameter int unsigned P_CNT_W   = CNT_W,
    parameter int unsigned P_N_EVT   = N_EVT,
    parameter int unsigned P_N_MATCH = N_MATCH,
    localparam int unsigned SEL_W    = $clog2(P_N_MATCH)
) (
    input  logic [P_CNT_W-1:0]                count_i,
    input  logic                              step_i,
    input  logic [P_N_MATCH-1:0][P_CNT_W-1:0] match_i,
    input  logic [P_N_EVT-1:0][SEL_W-1:0]     sel_i,
    input  logic [P_N_EVT-1:0][MODE_W-1:0]    mode_i,
    input  logic [P_N_EVT-1:0]                arm_i,
    output logic [P_N_EVT-1:0]                hit_o
);
    for (genvar n = 0; n < P_N_EVT; n++) begin : g_evt
        logic eq;
        assign eq       = (count_i == match_i[sel_i[n]]);
        assign hit_o[n] = step_i && arm_i[n] && (mode_i[n] == MODE_MATCH_ONLY) && eq;
    end
endmodule

// File: rtl/evt_timer_core.sv
module evt_timer_core
    import evt_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_en,
    input  logic [11:0]       bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [15:0]       evt_o
);
    localparam int unsigned SEL_W = $clog2(N_MATCH);

    logic                            freeze_w;
    logic [DIV_W-1:0]                div_w;
    logic [N_EVT-1:0]                limit_w;
    logic [N_MATCH-1:0][CNT_W-1:0]   match_w;
    logic [N_EVT-1:0][SEL_W-1:0]     sel_w;
    logic [N_EVT-1:0][MODE_W-1:0]    mode_w;
    logic [N_EVT-1:0]                arm_w;
    logic [CNT_W-1:0]                count_w;
    logic                            step_w;
    logic [N_EVT-1:0]                hit_w;
    logic                            restart_w;

    assign restart_w = |(hit_w & limit_w);
    assign evt_o     = hit_w;

    evt_regfile u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr_i (bus_addr),
        .bus_we_i   (bus_we),
        .bus_wdata_i(bus_wdata),
        .bus_rdata_o(bus_rdata),
        .restart_i  (restart_w),
        .freeze_o   (freeze_w),
        .div_o      (div_w),
        .limit_o    (limit_w),
        .match_o    (match_w),
        .sel_o      (sel_w),
        .mode_o     (mode_w),
        .arm_o      (arm_w)
    );

    evt_counter u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_en_i  (cnt_en),
        .freeze_i  (freeze_w),
        .div_i     (div_w),
        .restart_i (restart_w),
        .count_o   (count_w),
        .step_o    (step_w)
    );

    evt_match u_match (
        .count_i (count_w),
        .step_i  (step_w),
        .match_i (match_w),
        .sel_i   (sel_w),
        .mode_i  (mode_w),
        .arm_i   (arm_w),
        .hit_o   (hit_w)
    );
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cnt_en,
    input logic        freeze,
    input logic        step,
    input logic [31:0] count,
    input logic [15:0] limit,
    input logic [15:0] evt
);
    // R6: halted core is silent
    a_r6_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |-> (evt == 16'd0));

    // R6: halted core holds its count
    a_r6_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> (count == $past(count)));

    // R4: limit event returns counter to zero
    a_r4_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt & limit)) |=> (count == 32'd0));

    // R5: ordinary step advances by one
    a_r5_step_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !(|(evt & limit))) |=> (count == $past(count) + 32'd1));

    // R3: events only during a step
    a_r3_evt_on_step: assert property (@(posedge clk) disable iff (!rst_n)
        !step |-> (evt == 16'd0));

    // R11: no enable, no movement
    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en |=> (count == $past(count)));
endmodule

bind evt_timer_core evt_timer_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cnt_en (cnt_en),
    .freeze (freeze_w),
    .step   (step_w),
    .count  (count_w),
    .limit  (limit_w),
    .evt    (evt_o)
);

// File: tb/evt_timer_core_tb_top.sv
module evt_timer_core_tb_top;
    localparam logic [11:0] AD_CFG = 12'h000;
    localparam logic [11:0] AD_CTL = 12'h004;
    localparam logic [11:0] AD_LIM = 12'h008;
    localparam int NROW = 5;
    // per, duty, prescaler
    localparam int ROWS [NROW][3] = '{'{9,3,0}, '{4,0,0}, '{7,6,2}, '{2,5,1}, '{0,0,0}};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_en = 1'b1;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] evt_o;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    evt_timer_core dut_i (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .evt_o(evt_o)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic watch(input int ncyc, input int per_len, input int off,
                         output int n0, output int n1, output int bad0, output int bad1);
        int last0;
        last0 = -1; n0 = 0; n1 = 0; bad0 = 0; bad1 = 0;
        for (int c = 0; c < ncyc; c++) begin
            @(negedge clk);
            #1;
            if (evt_o[0]) begin
                if (last0 >= 0 && (c - last0) != per_len) bad0++;
                last0 = c;
                n0++;
            end
            if (evt_o[1]) begin
                n1++;
                if (last0 >= 0 && ((c - last0) % per_len) != off) bad1++;
            end
        end
    endtask

    task automatic setup(input int per, input int duty, input int dv, input bit keep);
        do_reset();
        wr(12'h100, 32'(per));  wr(12'h200, 32'(per));
        wr(12'h104, 32'(duty)); wr(12'h204, 32'(duty));
        wr(12'h300, 32'hFFFF_FFFF); wr(12'h308, 32'hFFFF_FFFF);
        wr(12'h304, 32'h0000_1000); wr(12'h30C, 32'h0000_1001);
        wr(AD_LIM, 32'h1);
        wr(AD_CFG, keep ? 32'h81 : 32'h1);
        wr(AD_CTL, 32'(dv) << 5);
    endtask

    initial begin
        #(4 * 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int n0, n1, b0, b1;

        // R1 reset state
        do_reset();
        #1;
        check(evt_o == 16'd0, "R1 evt after reset", evt_o, 0);
        rd(AD_CTL, v);
        check(v == 32'h4, "R1 ctl after reset", v, 4);
        rd(12'h304, v);
        check(v == 32'h0, "R1 evctl0 after reset", v, 0);
        watch(20, 1, 0, n0, n1, b0, b1);
        check(n0 == 0 && n1 == 0, "R1 no events while reset-halted", n0 + n1, 0);

        // R2 readback
        wr(AD_CTL, 32'h4 | 32'h10 | (32'hAB << 5));
        rd(AD_CTL, v);
        check(v == (32'h14 | (32'hAB << 5)), "R2 ctl readback", v, 32'h14 | (32'hAB << 5));
        wr(AD_CFG, 32'h81);
        rd(AD_CFG, v);
        check(v == 32'h81, "R2 cfg readback", v, 32'h81);
        wr(12'h13C, 32'hDEAD_BEEF);
        rd(12'h13C, v);
        check(v == 32'hDEAD_BEEF, "R2 match15 readback", v, 32'hDEAD_BEEF);
        wr(AD_LIM, 32'hFFFF);
        rd(AD_LIM, v);
        check(v == 32'hFFFF, "R2 limit readback", v, 32'hFFFF);
        wr(12'h37C, 32'h0000_2ABC);
        rd(12'h37C, v);
        check(v == 32'h2ABC, "R2 evctl15 readback", v, 32'h2ABC);

        // R4 / R5 table of period, duty, prescaler
        for (int r = 0; r < NROW; r++) begin
            int per, duty, dv, plen, off;
            per = ROWS[r][0]; duty = ROWS[r][1]; dv = ROWS[r][2];
            plen = (per + 1) * (dv + 1);
            off  = ((duty + 1) * (dv + 1)) % plen;
            setup(per, duty, dv, 1'b0);
            watch(4 * plen + 8, plen, off, n0, n1, b0, b1);
            check(b0 == 0 && n0 >= 3, "R4 R5 period spacing", b0, 0);
            if (duty <= per)
                check(b1 == 0 && n1 >= 3, "R4 R5 compare offset", b1, 0);
            else
                check(n1 == 0, "R4 compare beyond period silent", n1, 0);
        end

        // R6 halt
        setup(9, 3, 0, 1'b0);
        watch(20, 10, 4, n0, n1, b0, b1);
        wr(AD_CTL, 32'h4);
        watch(40, 10, 4, n0, n1, b0, b1);
        check(n0 == 0 && n1 == 0, "R6 no events while halted", n0 + n1, 0);
        wr(AD_CTL, 32'h0);
        watch(40, 10, 4, n0, n1, b0, b1);
        check(n0 >= 3 && b0 == 0, "R6 resume after halt", n0, 3);

        // R7 state mask
        setup(9, 3, 0, 1'b0);
        wr(12'h308, 32'hFFFF_FFFE);
        watch(40, 10, 4, n0, n1, b0, b1);
        check(n1 == 0 && n0 >= 3, "R7 masked event silent", n1, 0);

        // R8 control zero / wrong combine mode
        setup(9, 3, 0, 1'b0);
        wr(12'h30C, 32'h0);
        watch(40, 10, 4, n0, n1, b0, b1);
        check(n1 == 0 && n0 >= 3, "R8 zero control silent", n1, 0);
        wr(12'h30C, 32'h0000_2001);
        watch(40, 10, 4, n0, n1, b0, b1);
        check(n1 == 0, "R8 combine mode 2 silent", n1, 0);

        // R3 select bits 3:0 choose match register 2
        wr(12'h108, 32'd5); wr(12'h208, 32'd5);
        wr(12'h30C, 32'h0000_1002);
        watch(60, 10, 6, n0, n1, b0, b1);
        check(n1 >= 3 && b1 == 0, "R3 select match2 offset", b1, 0);

        // R9 deferred reload
        setup(9, 3, 0, 1'b0);
        wr(AD_CTL, 32'h4);
        wr(12'h200, 32'd4);
        rd(12'h100, v);
        check(v == 32'd9, "R9 match unchanged before boundary", v, 9);
        wr(AD_CTL, 32'h0);
        watch(14, 10, 4, n0, n1, b0, b1);
        watch(30, 5, 4, n0, n1, b0, b1);
        check(b0 == 0 && n0 >= 5 && b1 == 0, "R9 new period after boundary", b0, 0);
        rd(12'h100, v);
        check(v == 32'd4, "R9 match refreshed", v, 4);

        // R10 reload inhibit
        setup(9, 3, 0, 1'b1);
        wr(AD_CTL, 32'h4);
        wr(12'h200, 32'd4);
        wr(AD_CTL, 32'h0);
        watch(14, 10, 4, n0, n1, b0, b1);
        watch(40, 10, 4, n0, n1, b0, b1);
        check(b0 == 0 && n0 >= 3, "R10 period kept", b0, 0);
        rd(12'h100, v);
        check(v == 32'd9, "R10 match not refreshed", v, 9);

        // R11 count enable low
        setup(9, 3, 0, 1'b0);
        cnt_en = 1'b0;
        watch(40, 10, 4, n0, n1, b0, b1);
        check(n0 == 0 && n1 == 0, "R11 no events without enable", n0 + n1, 0);
        cnt_en = 1'b1;
        watch(30, 10, 4, n0, n1, b0, b1);
        check(n0 >= 2 && b0 == 0, "R11 resumes with enable", n0, 2);

        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule